// File: doc/BRIEF.md
# Ethernet Transmit Packet FIFO

This block buffers outgoing frames between a user streaming source and a MAC transmit engine, all on one clock. The user side is a valid/ready stream with start-of-packet and end-of-packet markers. Its ready may be honoured with a fixed latency. When `RDY_LAT` is non-zero, a word presented with `in_valid` is taken if `in_ready` was high `RDY_LAT` cycles earlier. Once ready falls, the source must stop presenting words within that many cycles.

The MAC side is a valid/ready pull interface. A beat moves when `out_valid` and `out_ready` are both high. Once raised, `out_valid` and `out_data` hold until the beat is taken. Each beat carries the start, end and error markers.

Four threshold inputs steer the FIFO:
- A start level sets how full the FIFO must be before a frame may be sent. Zero selects store-and-forward.
- A free-space warning level sets when the user is warned that space is running low.
- A full margin sets when ready is withdrawn.
- An abort level sets when a starving frame is cut short.

A frame that runs dry is ended with an error beat instead of stalling the MAC. The rest of that frame is then discarded on the user side.

Top module: `eth_tx_pkt_fifo`

## Requirements
- R1: After reset `out_valid`, `space_warn` and `almost_full` are 0, `in_ready` is 1 (with a full margin below the depth).
- R2: With a non-zero start level, `out_valid` is raised for a new frame in the cycle the stored word count first reaches the start level.
- R3: With a start level of 0, no frame is offered until its end-of-packet word is stored. The frame then leaves in order, first beat with `out_sop`=1, last beat with `out_eop`=1.
- R4: A complete stored frame is offered even when it is shorter than the start level.
- R5: `space_warn` is 1 exactly when the free space (DEPTH minus stored words) is below `cfg_warn_free`.
- R6: `almost_full` is 1 and `in_ready` is 0 exactly when the stored word count is at least DEPTH minus `cfg_full_margin`.
- R7: Words presented within `RDY_LAT` cycles after `in_ready` falls are stored and delivered. The FIFO never writes when full.
- R8: While a frame is being sent, no end-of-packet word is stored and the stored count is at or below `cfg_abort_lvl`, the stored words are discarded. One beat then follows with `out_eop`=1, `out_err`=1, `out_sop`=0 and data 0, and the FIFO never reads when empty.
- R9: After such an abort, user words of the cut frame are dropped up to and including its end-of-packet word. The next frame is delivered intact.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` stay unchanged.
- R11: Every beat of a frame that was not aborted has `out_err`=0, and words keep their write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start_lvl | input | LVL_W | Fill level that allows readout; 0 = store-and-forward |
| cfg_warn_free | input | LVL_W | Free-space level below which `space_warn` is raised |
| cfg_full_margin | input | LVL_W | Free-space margin at which ready is withdrawn |
| cfg_abort_lvl | input | LVL_W | Fill level at which a starving frame is aborted |
| in_valid | input | 1 | User word present |
| in_ready | output | 1 | FIFO accepts words (subject to `RDY_LAT`) |
| in_sop | input | 1 | User word starts a frame |
| in_eop | input | 1 | User word ends a frame |
| in_data | input | DATA_W | User word |
| out_valid | output | 1 | Beat offered to the MAC |
| out_ready | input | 1 | MAC takes the beat |
| out_sop | output | 1 | Beat starts a frame |
| out_eop | output | 1 | Beat ends a frame |
| out_err | output | 1 | Frame was aborted on underrun |
| out_data | output | DATA_W | Beat data |
| space_warn | output | 1 | Free space below the warning level |
| almost_full | output | 1 | Fill level inside the full margin |

## Verification
The assertions take for granted that the user source respects ready latency, so no write arrives when the FIFO is full. They also assume the full margin is at least `RDY_LAT` and that frames are well formed, with an end marker after each start marker. The thresholds are assumed to stay constant while traffic flows. The stimulus presents a word only when the bench's own copy of the delayed ready is high, and it changes thresholds only while the FIFO is empty. Each frame is built as a start word, body words and an end word, and the underrun case pauses the source in the middle of a frame on purpose.

// File: rtl/txpf_pkg.sv
package txpf_pkg;

  // Readout sequencer states
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,  // between frames, waiting for the start rule
    RD_SEND  = 2'd1,  // inside a frame
    RD_ABORT = 2'd2   // presenting the error beat of a cut frame
  } rd_state_e;

endpackage

// File: rtl/txpf_store.sv
module txpf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              flush,
  output logic              head_sop,
  output logic              head_eop,
  output logic [DATA_W-1:0] head_data,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  pkt_cnt
);

  typedef struct packed {
    logic              sop;
    logic              eop;
    logic [DATA_W-1:0] data;
  } entry_t;

  entry_t            mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  entry_t            head;
  logic              pkt_in;
  logic              pkt_out;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= '{sop: wr_sop, eop: wr_eop, data: wr_data};
  end

  assign head      = mem[rd_ptr];
  assign head_sop  = head.sop;
  assign head_eop  = head.eop;
  assign head_data = head.data;

  assign pkt_in  = wr_en & wr_eop;
  assign pkt_out = rd_en & head.eop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + PTR_W'(1);
      if (flush)      rd_ptr <= wr_ptr;
      else if (rd_en) rd_ptr <= rd_ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else if (flush) begin
      level <= '0;
    end else begin
      case ({wr_en, rd_en})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_cnt <= '0;
    end else if (flush) begin
      pkt_cnt <= '0;
    end else begin
      case ({pkt_in, pkt_out})
        2'b10:   pkt_cnt <= pkt_cnt + LVL_W'(1);
        2'b01:   pkt_cnt <= pkt_cnt - LVL_W'(1);
        default: pkt_cnt <= pkt_cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (level != LVL_W'(DEPTH))); // R7
  AST_PKT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_cnt <= level); // R4
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0) && (pkt_cnt == '0)); // R9

endmodule

// File: rtl/txpf_wr_ctrl.sv
module txpf_wr_ctrl #(
  parameter int DEPTH   = 64,
  parameter int RDY_LAT = 0,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] warn_free,
  input  logic [LVL_W-1:0] full_margin,
  input  logic             flush,
  output logic             in_ready,
  output logic             space_warn,
  output logic             almost_full,
  output logic             wr_en
);

  localparam logic [LVL_W:0] DEPTH_X = (LVL_W + 1)'(DEPTH);

  logic [LVL_W:0] level_x;
  logic           grant;
  logic           accept;
  logic           open_q;
  logic           open_d;
  logic           drop_q;
  logic           drop_d;

  assign level_x     = {1'b0, level};
  assign almost_full = (level_x + {1'b0, full_margin}) >= DEPTH_X;
  assign space_warn  = (level_x + {1'b0, warn_free}) > DEPTH_X;
  assign in_ready    = ~almost_full;

  // Ready as seen by the source after the configured latency
  generate
    if (RDY_LAT == 0) begin : g_lat_zero
      assign grant = in_ready;
    end else begin : g_lat_pipe
      logic [RDY_LAT-1:0] rdy_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rdy_q <= '0;
        end else begin
          rdy_q[0] <= in_ready;
          for (int i = 1; i < RDY_LAT; i++) rdy_q[i] <= rdy_q[i-1];
        end
      end
      assign grant = rdy_q[RDY_LAT-1];
    end
  endgenerate

  assign accept = in_valid & grant;
  assign wr_en  = accept & ~drop_q & ~flush;

  // Frame tracking on the user side, independent of storage
  always_comb begin
    open_d = open_q;
    if (accept) begin
      if (in_eop)      open_d = 1'b0;
      else if (in_sop) open_d = 1'b1;
    end
  end

  always_comb begin
    drop_d = drop_q;
    if (flush)                          drop_d = open_d;
    else if (drop_q && accept && in_eop) drop_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      open_q <= open_d;
      drop_q <= drop_d;
    end
  end

  AST_DROP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q && accept && in_eop && !flush) |=> !drop_q); // R9
  AST_FULL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(DEPTH)) |-> !in_ready); // R6

endmodule

// File: rtl/txpf_rd_ctrl.sv
module txpf_rd_ctrl
  import txpf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  level,
  input  logic [LVL_W-1:0]  pkt_cnt,
  input  logic              head_sop,
  input  logic              head_eop,
  input  logic [DATA_W-1:0] head_data,
  input  logic [LVL_W-1:0]  start_lvl,
  input  logic [LVL_W-1:0]  abort_lvl,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_err,
  output logic [DATA_W-1:0] out_data,
  output logic              rd_en,
  output logic              flush
);

  rd_state_e state_q;
  rd_state_e state_d;
  logic      have_pkt;
  logic      start_ok;
  logic      starve;

  assign have_pkt = (pkt_cnt != '0);
  assign start_ok = have_pkt || ((start_lvl != '0) && (level >= start_lvl));
  assign starve   = !have_pkt && (level <= abort_lvl);

  always_comb begin
    state_d   = state_q;
    out_valid = 1'b0;
    out_sop   = head_sop;
    out_eop   = head_eop;
    out_err   = 1'b0;
    out_data  = head_data;
    flush     = 1'b0;
    case (state_q)
      RD_IDLE: begin
        out_valid = start_ok;
        if (start_ok && out_ready) state_d = head_eop ? RD_IDLE : RD_SEND;
      end
      RD_SEND: begin
        if (starve) begin
          flush   = 1'b1;
          state_d = RD_ABORT;
        end else begin
          out_valid = 1'b1;
          if (out_ready && head_eop) state_d = RD_IDLE;
        end
      end
      RD_ABORT: begin
        out_valid = 1'b1;
        out_sop   = 1'b0;
        out_eop   = 1'b1;
        out_err   = 1'b1;
        out_data  = '0;
        if (out_ready) state_d = RD_IDLE;
      end
      default: state_d = RD_IDLE;
    endcase
  end

  assign rd_en = out_valid & out_ready & (state_q != RD_ABORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RD_IDLE;
    else        state_q <= state_d;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (level != '0)); // R8
  AST_SAF_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RD_IDLE && start_lvl == '0 && pkt_cnt == '0) |-> !out_valid); // R3
  AST_ERR_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_eop && !out_sop)); // R8
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

endmodule

// File: rtl/eth_tx_pkt_fifo.sv
module eth_tx_pkt_fifo #(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 64,
  parameter int RDY_LAT = 0,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  cfg_start_lvl,
  input  logic [LVL_W-1:0]  cfg_warn_free,
  input  logic [LVL_W-1:0]  cfg_full_margin,
  input  logic [LVL_W-1:0]  cfg_abort_lvl,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_err,
  output logic [DATA_W-1:0] out_data,
  output logic              space_warn,
  output logic              almost_full
);

  logic              wr_en;
  logic              rd_en;
  logic              flush;
  logic              head_sop;
  logic              head_eop;
  logic [DATA_W-1:0] head_data;
  logic [LVL_W-1:0]  level;
  logic [LVL_W-1:0]  pkt_cnt;

  txpf_wr_ctrl #(
    .DEPTH   (DEPTH),
    .RDY_LAT (RDY_LAT),
    .LVL_W   (LVL_W)
  ) wr_ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sop      (in_sop),
    .in_eop      (in_eop),
    .level       (level),
    .warn_free   (cfg_warn_free),
    .full_margin (cfg_full_margin),
    .flush       (flush),
    .in_ready    (in_ready),
    .space_warn  (space_warn),
    .almost_full (almost_full),
    .wr_en       (wr_en)
  );

  txpf_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .LVL_W  (LVL_W)
  ) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sop    (in_sop),
    .wr_eop    (in_eop),
    .wr_data   (in_data),
    .rd_en     (rd_en),
    .flush     (flush),
    .head_sop  (head_sop),
    .head_eop  (head_eop),
    .head_data (head_data),
    .level     (level),
    .pkt_cnt   (pkt_cnt)
  );

  txpf_rd_ctrl #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .LVL_W  (LVL_W)
  ) rd_ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (level),
    .pkt_cnt   (pkt_cnt),
    .head_sop  (head_sop),
    .head_eop  (head_eop),
    .head_data (head_data),
    .start_lvl (cfg_start_lvl),
    .abort_lvl (cfg_abort_lvl),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_err   (out_err),
    .out_data  (out_data),
    .rd_en     (rd_en),
    .flush     (flush)
  );

endmodule

// File: tb/eth_tx_pkt_fifo_tb_top.sv
module eth_tx_pkt_fifo_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int DEPTH      = 64;
  localparam int RDY_LAT    = 1;
  localparam int LVL_W      = $clog2(DEPTH + 1);
  localparam int WD_CYCLES  = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [LVL_W-1:0]  cfg_start_lvl = LVL_W'(4);
  logic [LVL_W-1:0]  cfg_warn_free = LVL_W'(48);
  logic [LVL_W-1:0]  cfg_full_margin = LVL_W'(4);
  logic [LVL_W-1:0]  cfg_abort_lvl = LVL_W'(1);
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic              in_sop = 1'b0;
  logic              in_eop = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic              out_sop;
  logic              out_eop;
  logic              out_err;
  logic [DATA_W-1:0] out_data;
  logic              space_warn;
  logic              almost_full;

  int n_checks = 0;
  int n_errors = 0;
  logic bench_grant;
  logic [DATA_W+2:0] got_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_tx_pkt_fifo #(
    .DATA_W  (DATA_W),
    .DEPTH   (DEPTH),
    .RDY_LAT (RDY_LAT)
  ) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_start_lvl   (cfg_start_lvl),
    .cfg_warn_free   (cfg_warn_free),
    .cfg_full_margin (cfg_full_margin),
    .cfg_abort_lvl   (cfg_abort_lvl),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .in_sop          (in_sop),
    .in_eop          (in_eop),
    .in_data         (in_data),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_sop         (out_sop),
    .out_eop         (out_eop),
    .out_err         (out_err),
    .out_data        (out_data),
    .space_warn      (space_warn),
    .almost_full     (almost_full)
  );

  // Bench model of ready delayed by one cycle (RDY_LAT = 1)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bench_grant <= 1'b0;
    else        bench_grant <= in_ready;
  end

  // Beat collector: {err, sop, eop, data}
  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready)
      got_q.push_back({out_err, out_sop, out_eop, out_data});
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  task automatic put_word(input logic [DATA_W-1:0] d, input logic s, input logic e);
    forever begin
      @(negedge clk);
      if (bench_grant) break;
      in_valid = 1'b0;
    end
    in_valid = 1'b1;
    in_sop   = s;
    in_eop   = e;
    in_data  = d;
  endtask

  task automatic go_idle;
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic wait_beats(input int n);
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (got_q.size() >= n) break;
    end
    repeat (4) @(negedge clk);
  endtask

  // Check a normal frame of n words starting at base in got_q[at..]
  task automatic check_frame(input string req, input int at, input int n,
                             input logic [DATA_W-1:0] base);
    for (int i = 0; i < n; i++) begin
      logic [DATA_W+2:0] b;
      b = got_q[at + i];
      check(b[DATA_W-1:0] == base + DATA_W'(i), req, "frame data", b[DATA_W-1:0], base + DATA_W'(i));
      check(b[DATA_W+1] == (i == 0), req, "sop marker", b[DATA_W+1], (i == 0));
      check(b[DATA_W] == (i == n - 1), req, "eop marker", b[DATA_W], (i == n - 1));
      check(b[DATA_W+2] == 1'b0, "R11", "err on normal beat", b[DATA_W+2], 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(space_warn == 1'b0, "R1", "space_warn after reset", space_warn, 0);
    check(almost_full == 1'b0, "R1", "almost_full after reset", almost_full, 0);
  endtask

  task automatic t_cut_through;
    got_q.delete();
    cfg_start_lvl = LVL_W'(4);
    cfg_abort_lvl = LVL_W'(1);
    out_ready = 1'b0;
    for (int i = 0; i < 6; i++) begin
      put_word(32'hA000_0000 + i, (i == 0), 1'b0);
      check(out_valid == (i >= 4), "R2", "out_valid vs stored count", out_valid, (i >= 4));
    end
    put_word(32'hA000_0006, 1'b0, 1'b1);
    go_idle();
    out_ready = 1'b1;
    wait_beats(7);
    check(got_q.size() == 7, "R2", "beats delivered", got_q.size(), 7);
    if (got_q.size() == 7) check_frame("R2", 0, 7, 32'hA000_0000);
    out_ready = 1'b0;
  endtask

  task automatic t_store_forward;
    got_q.delete();
    cfg_start_lvl = '0;
    cfg_abort_lvl = '0;
    out_ready = 1'b1;
    for (int i = 0; i < 5; i++) put_word(32'hB000_0000 + i, (i == 0), 1'b0);
    go_idle();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R3", "offered before eop stored", out_valid, 0);
    check(got_q.size() == 0, "R3", "beats before eop stored", got_q.size(), 0);
    put_word(32'hB000_0005, 1'b0, 1'b1);
    go_idle();
    wait_beats(6);
    check(got_q.size() == 6, "R3", "beats delivered", got_q.size(), 6);
    if (got_q.size() == 6) check_frame("R3", 0, 6, 32'hB000_0000);
    out_ready = 1'b0;
  endtask

  task automatic t_short_packet;
    got_q.delete();
    cfg_start_lvl = LVL_W'(16);
    cfg_abort_lvl = LVL_W'(1);
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) put_word(32'hC000_0000 + i, (i == 0), (i == 2));
    go_idle();
    wait_beats(3);
    check(got_q.size() == 3, "R4", "short frame delivered", got_q.size(), 3);
    if (got_q.size() == 3) check_frame("R4", 0, 3, 32'hC000_0000);
    out_ready = 1'b0;
  endtask

  task automatic t_flags;
    int lvl;
    got_q.delete();
    cfg_start_lvl = LVL_W'(4);
    cfg_warn_free = LVL_W'(40);
    cfg_full_margin = LVL_W'(4);
    out_ready = 1'b0;
    lvl = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      check(space_warn == ((DEPTH - lvl) < 40), "R5", "space_warn", space_warn, ((DEPTH - lvl) < 40));
      check(almost_full == (lvl >= DEPTH - 4), "R6", "almost_full", almost_full, (lvl >= DEPTH - 4));
      check(in_ready == (lvl < DEPTH - 4), "R6", "in_ready", in_ready, (lvl < DEPTH - 4));
      if (bench_grant) begin
        in_valid = 1'b1;
        in_sop   = 1'b1;
        in_eop   = 1'b1;
        in_data  = 32'hD000_0000 + lvl;
        lvl++;
      end else begin
        in_valid = 1'b0;
        break;
      end
    end
    in_sop = 1'b0;
    in_eop = 1'b0;
    check(lvl == DEPTH - 4 + RDY_LAT, "R7", "words taken incl. latency", lvl, DEPTH - 4 + RDY_LAT);
    out_ready = 1'b1;
    wait_beats(lvl);
    check(got_q.size() == lvl, "R7", "words delivered", got_q.size(), lvl);
    if (got_q.size() == lvl) begin
      for (int i = 0; i < lvl; i++) check_frame("R7", i, 1, 32'hD000_0000 + i);
    end
    out_ready = 1'b0;
    cfg_warn_free = LVL_W'(48);
  endtask

  task automatic t_abort;
    logic [DATA_W+2:0] b;
    got_q.delete();
    cfg_start_lvl = LVL_W'(4);
    cfg_abort_lvl = LVL_W'(2);
    out_ready = 1'b1;
    for (int i = 0; i < 6; i++) put_word(32'hE000_0000 + i, (i == 0), 1'b0);
    go_idle();
    repeat (12) @(negedge clk);
    // tail of the cut frame, must be dropped
    put_word(32'hEEEE_0000, 1'b0, 1'b0);
    put_word(32'hEEEE_0001, 1'b0, 1'b1);
    // next frame, must arrive intact
    for (int i = 0; i < 3; i++) put_word(32'hF000_0000 + i, (i == 0), (i == 2));
    go_idle();
    wait_beats(8);
    check(got_q.size() == 8, "R8", "beats incl. abort", got_q.size(), 8);
    if (got_q.size() == 8) begin
      for (int i = 0; i < 4; i++) begin
        b = got_q[i];
        check(b[DATA_W-1:0] == 32'hE000_0000 + i, "R8", "prefix data", b[DATA_W-1:0], 32'hE000_0000 + i);
        check(b[DATA_W] == 1'b0, "R8", "prefix eop", b[DATA_W], 0);
        check(b[DATA_W+2] == 1'b0, "R11", "prefix err", b[DATA_W+2], 0);
      end
      b = got_q[4];
      check(b[DATA_W+2] == 1'b1, "R8", "abort err", b[DATA_W+2], 1);
      check(b[DATA_W] == 1'b1, "R8", "abort eop", b[DATA_W], 1);
      check(b[DATA_W+1] == 1'b0, "R8", "abort sop", b[DATA_W+1], 0);
      check(b[DATA_W-1:0] == '0, "R8", "abort data", b[DATA_W-1:0], 0);
      check_frame("R9", 5, 3, 32'hF000_0000);
    end
    out_ready = 1'b0;
    cfg_abort_lvl = LVL_W'(1);
  endtask

  task automatic t_hold;
    logic [DATA_W-1:0] held;
    got_q.delete();
    cfg_start_lvl = '0;
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) put_word(32'h1230_0000 + i, (i == 0), (i == 2));
    go_idle();
    @(negedge clk);
    check(out_valid == 1'b1, "R10", "offered while stalled", out_valid, 1);
    held = out_data;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R10", "valid held", out_valid, 1);
      check(out_data == held, "R10", "data held", out_data, held);
    end
    out_ready = 1'b1;
    wait_beats(3);
    check(got_q.size() == 3, "R10", "beats after stall", got_q.size(), 3);
    if (got_q.size() == 3) check_frame("R10", 0, 3, 32'h1230_0000);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cut_through();
    t_store_forward();
    t_short_packet();
    t_flags();
    t_abort();
    t_hold();
    finish_run();
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not complete in %0d cycles", WD_CYCLES);
    finish_run();
  end

endmodule